// File: doc/BRIEF.md
# Double-Buffered Bulk Endpoint Buffer Controller

This block keeps the bookkeeping for a pair of packet buffers behind one bulk endpoint of a USB device. The packet data lives elsewhere. Here each buffer is just a full bit and a byte count. Software works through a pointer that alternates between the two buffers on its own commands. The serial engine works through a second pointer that alternates only when a packet has really moved into or out of a buffer. Because the two pointers move independently, software can fill or drain one buffer while the engine uses the other.

The endpoint can transmit (IN) or receive (OUT). The direction is fixed by a parameter, or taken from a configuration input. For an IN endpoint, software validates buffers that it has filled. The engine then sends them in the order they were validated and answers IN tokens with either "data ready" or NAK. For an OUT endpoint, the engine accepts packets into free buffers or refuses them with NAK, and software hands each drained buffer back with a clear command. A single pending interrupt collects every completed transfer, and also each NAK when that option is enabled. Software reads the full flag, byte count, pointer and a sticky error flag through a select status read.

Top module: `dbuf_ep_ctrl`

## Requirements
- R1: After reset both buffers are empty with length 0, both pointers refer to buffer 0 (B_1), and the interrupt and error flags are 0.
- R2: In IN direction, a validate command on an empty software-active buffer marks it full, stores `sw_len_wr` as its length, and moves the software pointer to the other buffer.
- R3: In OUT direction, a clear command on a full software-active buffer marks it empty and moves the software pointer to the other buffer.
- R4: A pulse on `sw_select` gives `st_vld` high in the next cycle. Along with it come `st_full` (1 means the software-active buffer holds data), `st_len` (its length) and `st_ptr` (0 means buffer 0), all taken from the state as it stood before that cycle's commands.
- R5: In IN direction, an IN token in the same cycle raises `se_tx_rdy`, with `se_tx_len` giving the hardware-side buffer's length, when that buffer is full. Otherwise it raises `se_nak`. The two outputs are never high together.
- R6: In IN direction, a transmit acknowledge while the hardware-side buffer is full empties that buffer, advances the hardware pointer and raises the interrupt, so buffers go out in the order they were validated. An acknowledge while that buffer is empty has no effect. Only completed transfers move the hardware pointer; software commands never do.
- R7: In OUT direction, a received packet is accepted (`se_rx_ack` high in the same cycle) when the hardware-side buffer is empty. It marks that buffer full with length `se_rx_len`, advances the hardware pointer and raises the interrupt. When that buffer is full, the packet is answered with `se_nak` and the state does not change.
- R8: A NAK raises the interrupt only when `cfg_nak_irq_en` is 1.
- R9: `ep_irq` stays high until `sw_irq_clr`. If a new interrupt event coincides with the clear, `ep_irq` stays high.
- R10: A validate command on a full buffer (IN) or a clear command on an empty buffer (OUT) changes no buffer and no pointer, and it sets the error flag. The flag is reported in `st_err` by the next select and is then cleared, unless a new error arrives in the same cycle as that select.
- R11: With parameter DIR_MODE = 2 the direction follows `cfg_dir_in` (1 = IN, 0 = OUT). A validate command in OUT direction, or a clear command in IN direction, is ignored and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | Direction when DIR_MODE = 2: 1 = IN, 0 = OUT |
| cfg_nak_irq_en | input | 1 | Raise the interrupt on NAK |
| sw_select | input | 1 | Status read request |
| sw_validate | input | 1 | Validate the software-active buffer (IN) |
| sw_clear | input | 1 | Free the software-active buffer (OUT) |
| sw_len_wr | input | LEN_W | Length stored on validate |
| sw_irq_clr | input | 1 | Clear the pending interrupt |
| st_vld | output | 1 | Status valid, one cycle after select |
| st_full | output | 1 | Software-active buffer holds data |
| st_len | output | LEN_W | Length of the software-active buffer |
| st_ptr | output | 1 | Software-active buffer index |
| st_err | output | 1 | Sticky command error |
| se_in_tok | input | 1 | IN token arrived |
| se_tx_ack | input | 1 | IN packet sent and acknowledged |
| se_rx_pkt | input | 1 | OUT packet received |
| se_rx_len | input | LEN_W | Received packet length |
| se_tx_rdy | output | 1 | Data ready for the IN token |
| se_tx_len | output | LEN_W | Length of the hardware-side buffer |
| se_nak | output | 1 | Answer with NAK |
| se_rx_ack | output | 1 | Received packet accepted |
| ep_irq | output | 1 | Endpoint interrupt pending |

## Verification
The bench builds the block with DIR_MODE = 2 and the default LEN_W = 7. Because the direction comes from the input, a single run can drive the IN path, switch `cfg_dir_in`, and then drive the OUT path with the pointers left wherever the IN traffic put them. The 7-bit length lets each buffer carry a distinct count. A buffer that is swapped or sent out of order therefore shows up in `st_len` or `se_tx_len`.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int NBUF = 2;
  typedef enum int {
    DIR_OUT = 0,
    DIR_IN  = 1,
    DIR_CFG = 2
  } dir_mode_e;
endpackage

// File: rtl/dbuf_store.sv
module dbuf_store
  import dbuf_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic [NBUF-1:0]            set_i,
  input  logic [NBUF-1:0]            clr_i,
  input  logic [NBUF-1:0][LEN_W-1:0] wlen_i,
  output logic [NBUF-1:0]            full_o,
  output logic [NBUF-1:0][LEN_W-1:0] len_o
);
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic             full_q, full_d, en;
    logic [LEN_W-1:0] len_q, len_d;

    always_comb begin
      en     = set_i[b] | clr_i[b];
      full_d = full_q;
      len_d  = len_q;
      if (set_i[b]) begin
        full_d = 1'b1;
        len_d  = wlen_i[b];
      end else if (clr_i[b]) begin
        full_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q <= 1'b0;
        len_q  <= '0;
      end else if (en) begin
        full_q <= full_d;
        len_q  <= len_d;
      end
    end

    assign full_o[b] = full_q;
    assign len_o[b]  = len_q;

    // R7
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      set_i[b] |=> full_o[b]);
    // R6
    full_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_i[b] && !set_i[b]) |=> !full_o[b]);
  end
endmodule

// File: rtl/dbuf_ptr.sv
module dbuf_ptr (
  input  logic clk,
  input  logic rst_ni,
  input  logic sw_adv_i,
  input  logic hw_adv_i,
  output logic sw_ptr_o,
  output logic hw_ptr_o
);
  logic sw_q, sw_d, hw_q, hw_d;

  always_comb begin
    sw_d = sw_q ^ sw_adv_i;
    hw_d = hw_q ^ hw_adv_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q <= 1'b0;
      hw_q <= 1'b0;
    end else begin
      if (sw_adv_i) sw_q <= sw_d;
      if (hw_adv_i) hw_q <= hw_d;
    end
  end

  assign sw_ptr_o = sw_q;
  assign hw_ptr_o = hw_q;
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags (
  input  logic clk,
  input  logic rst_ni,
  input  logic irq_set_i,
  input  logic irq_clr_i,
  input  logic err_set_i,
  input  logic err_rd_i,
  output logic irq_o,
  output logic err_o
);
  logic irq_q, irq_d, err_q, err_d;

  always_comb begin
    irq_d = irq_set_i | (irq_q & ~irq_clr_i);
    err_d = err_set_i | (err_q & ~err_rd_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign irq_o = irq_q;
  assign err_o = err_q;

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_set_i |=> irq_o);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_o && !err_rd_i) |=> err_o);
endmodule

// File: rtl/dbuf_ep_ctrl.sv
module dbuf_ep_ctrl
  import dbuf_pkg::*;
#(
  parameter int LEN_W    = 7,
  parameter int DIR_MODE = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cfg_dir_in,
  input  logic             cfg_nak_irq_en,
  input  logic             sw_select,
  input  logic             sw_validate,
  input  logic             sw_clear,
  input  logic [LEN_W-1:0] sw_len_wr,
  input  logic             sw_irq_clr,
  output logic             st_vld,
  output logic             st_full,
  output logic [LEN_W-1:0] st_len,
  output logic             st_ptr,
  output logic             st_err,
  input  logic             se_in_tok,
  input  logic             se_tx_ack,
  input  logic             se_rx_pkt,
  input  logic [LEN_W-1:0] se_rx_len,
  output logic             se_tx_rdy,
  output logic [LEN_W-1:0] se_tx_len,
  output logic             se_nak,
  output logic             se_rx_ack,
  output logic             ep_irq
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic                       dir_in;
  logic                       sw_ptr, hw_ptr, sw_full, hw_full;
  logic [NBUF-1:0]            full, set, clr;
  logic [NBUF-1:0][LEN_W-1:0] len, wlen;
  logic                       val_ok, val_bad, clr_ok, clr_bad;
  logic                       tx_done, rx_ok, in_nak, rx_nak;
  logic                       irq_set, err_set, err_flag;

  assign dir_in = (DIR_MODE == DIR_CFG) ? cfg_dir_in : (DIR_MODE == DIR_IN);

  always_comb begin
    sw_full = full[sw_ptr];
    hw_full = full[hw_ptr];
    val_ok  = sw_validate &  dir_in & ~sw_full;
    val_bad = sw_validate &  dir_in &  sw_full;
    clr_ok  = sw_clear    & ~dir_in &  sw_full;
    clr_bad = sw_clear    & ~dir_in & ~sw_full;
    tx_done = se_tx_ack   &  dir_in &  hw_full;
    rx_ok   = se_rx_pkt   & ~dir_in & ~hw_full;
    in_nak  = se_in_tok   &  dir_in & ~hw_full;
    rx_nak  = se_rx_pkt   & ~dir_in &  hw_full;
    irq_set = tx_done | rx_ok | ((in_nak | rx_nak) & cfg_nak_irq_en);
    err_set = val_bad | clr_bad;
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_dec
    assign set[b]  = (val_ok & (sw_ptr == b[0])) | (rx_ok & (hw_ptr == b[0]));
    assign clr[b]  = (clr_ok & (sw_ptr == b[0])) | (tx_done & (hw_ptr == b[0]));
    assign wlen[b] = (rx_ok & (hw_ptr == b[0])) ? se_rx_len : sw_len_wr;
  end

  dbuf_store #(.LEN_W(LEN_W)) u_store (
    .clk    (clk),
    .rst_ni (rst_int),
    .set_i  (set),
    .clr_i  (clr),
    .wlen_i (wlen),
    .full_o (full),
    .len_o  (len)
  );

  dbuf_ptr u_ptr (
    .clk      (clk),
    .rst_ni   (rst_int),
    .sw_adv_i (val_ok | clr_ok),
    .hw_adv_i (tx_done | rx_ok),
    .sw_ptr_o (sw_ptr),
    .hw_ptr_o (hw_ptr)
  );

  dbuf_flags u_flags (
    .clk       (clk),
    .rst_ni    (rst_int),
    .irq_set_i (irq_set),
    .irq_clr_i (sw_irq_clr),
    .err_set_i (err_set),
    .err_rd_i  (sw_select),
    .irq_o     (ep_irq),
    .err_o     (err_flag)
  );

  // engine answers, same cycle
  assign se_tx_rdy = se_in_tok & dir_in & hw_full;
  assign se_tx_len = len[hw_ptr];
  assign se_nak    = in_nak | rx_nak;
  assign se_rx_ack = rx_ok;

  // status read register
  logic             st_vld_d, st_full_d, st_ptr_d, st_err_d;
  logic [LEN_W-1:0] st_len_d;

  always_comb begin
    st_vld_d  = sw_select;
    st_full_d = sw_full;
    st_len_d  = len[sw_ptr];
    st_ptr_d  = sw_ptr;
    st_err_d  = err_flag;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_vld  <= 1'b0;
      st_full <= 1'b0;
      st_len  <= '0;
      st_ptr  <= 1'b0;
      st_err  <= 1'b0;
    end else begin
      st_vld <= st_vld_d;
      if (sw_select) begin
        st_full <= st_full_d;
        st_len  <= st_len_d;
        st_ptr  <= st_ptr_d;
        st_err  <= st_err_d;
      end
    end
  end

  // R5
  nak_rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_int)
    !(se_nak && se_tx_rdy));
  // R6
  tx_hwp_adv_chk: assert property (@(posedge clk) disable iff (!rst_int)
    tx_done |=> (hw_ptr != $past(hw_ptr)));
  // R6
  sw_only_hwp_chk: assert property (@(posedge clk) disable iff (!rst_int)
    ((sw_validate || sw_clear) && !se_tx_ack && !se_rx_pkt) |=> $stable(hw_ptr));
  // R4
  sel_vld_chk: assert property (@(posedge clk) disable iff (!rst_int)
    sw_select |=> st_vld);
  // R7
  rx_nak_keep_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (rx_nak && !sw_clear) |=> ($stable(full) && $stable(hw_ptr)));
endmodule

// File: tb/sim_dbuf_ep_ctrl.sv
`timescale 1ns/1ps
module sim_dbuf_ep_ctrl;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dir_in = 1'b1, cfg_nak_irq_en = 1'b1;
  logic sw_select = 0, sw_validate = 0, sw_clear = 0, sw_irq_clr = 0;
  logic [LW-1:0] sw_len_wr = '0, se_rx_len = '0;
  logic se_in_tok = 0, se_tx_ack = 0, se_rx_pkt = 0;
  logic st_vld, st_full, st_ptr, st_err, se_tx_rdy, se_nak, se_rx_ack, ep_irq;
  logic [LW-1:0] st_len, se_tx_len;

  always #4 clk = ~clk;

  dbuf_ep_ctrl #(.LEN_W(LW), .DIR_MODE(2)) u0 (
    .clk(clk), .rst_ni(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_nak_irq_en(cfg_nak_irq_en),
    .sw_select(sw_select), .sw_validate(sw_validate), .sw_clear(sw_clear),
    .sw_len_wr(sw_len_wr), .sw_irq_clr(sw_irq_clr),
    .st_vld(st_vld), .st_full(st_full), .st_len(st_len), .st_ptr(st_ptr), .st_err(st_err),
    .se_in_tok(se_in_tok), .se_tx_ack(se_tx_ack), .se_rx_pkt(se_rx_pkt), .se_rx_len(se_rx_len),
    .se_tx_rdy(se_tx_rdy), .se_tx_len(se_tx_len), .se_nak(se_nak), .se_rx_ack(se_rx_ack),
    .ep_irq(ep_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference state, kept from the requirements
  bit m_full[2];
  logic [LW-1:0] m_len[2];
  bit m_sw = 0, m_hw = 0, m_irq = 0, m_err = 0, m_dir = 1, m_nen = 1;

  // expected status items {full, len, ptr, err}
  logic [LW+2:0] expq[$];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic zero_in();
    sw_select = 0; sw_validate = 0; sw_clear = 0; sw_irq_clr = 0;
    se_in_tok = 0; se_tx_ack = 0; se_rx_pkt = 0;
  endtask

  task automatic set_cfg(input bit d, input bit n);
    @(negedge clk);
    zero_in();
    cfg_dir_in = d; cfg_nak_irq_en = n; m_dir = d; m_nen = n;
  endtask

  // one cycle of stimulus with its expected answers
  task automatic cyc(input string tag, input bit v, input bit c, input bit rx,
                     input bit ta, input bit it, input bit ic, input bit sl,
                     input logic [LW-1:0] ln);
    bit hf, sf, e_nak, e_rdy, e_ack, ow, oh, nerr;
    @(negedge clk);
    zero_in();
    sw_validate = v; sw_clear = c; se_rx_pkt = rx; se_tx_ack = ta;
    se_in_tok = it; sw_irq_clr = ic; sw_select = sl; sw_len_wr = ln; se_rx_len = ln;
    #1;
    hf = m_full[m_hw]; sf = m_full[m_sw];
    e_nak = (it & m_dir & ~hf) | (rx & ~m_dir & hf);
    e_rdy = it & m_dir & hf;
    e_ack = rx & ~m_dir & ~hf;
    check({tag, " R9 irq"}, ep_irq, m_irq);
    check({tag, " nak"}, se_nak, e_nak);
    check({tag, " R5 rdy"}, se_tx_rdy, e_rdy);
    check({tag, " R7 rx_ack"}, se_rx_ack, e_ack);
    if (e_rdy) check({tag, " R6 tx_len"}, se_tx_len, m_len[m_hw]);
    if (sl) expq.push_back({sf, m_len[m_sw], m_sw, m_err});
    nerr = (v & m_dir & sf) | (c & ~m_dir & ~sf);
    m_err = (m_err & ~sl) | nerr;
    m_irq = ((ta & m_dir & hf) | e_ack | (e_nak & m_nen)) | (m_irq & ~ic);
    ow = m_sw; oh = m_hw;
    if (ta & m_dir & hf) begin m_full[oh] = 0; m_hw = ~m_hw; end
    if (e_ack) begin m_full[oh] = 1; m_len[oh] = ln; m_hw = ~m_hw; end
    if (v & m_dir & ~sf) begin m_full[ow] = 1; m_len[ow] = ln; m_sw = ~m_sw; end
    if (c & ~m_dir & sf) begin m_full[ow] = 0; m_sw = ~m_sw; end
  endtask

  task automatic sel(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 1, '0);
  endtask

  // monitor: status results against the scoreboard queue (R4, R10)
  always @(negedge clk) begin
    if (rst_n && st_vld) begin
      if (expq.size() == 0) begin
        check("R4 unexpected st_vld", 1, 0);
      end else begin
        logic [LW+2:0] e;
        e = expq.pop_front();
        check("R4 st_full", st_full, e[LW+2]);
        check("R4 st_len", st_len, e[LW+1:2]);
        check("R4 st_ptr", st_ptr, e[1]);
        check("R10 st_err", st_err, e[0]);
      end
    end
  end

  initial begin
    m_full[0] = 0; m_full[1] = 0; m_len[0] = 0; m_len[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // R1: reset state through a status read
    sel("R1 reset");
    // IN direction, NAK interrupt on
    cyc("R5 R8 in_tok empty", 0, 0, 0, 0, 1, 0, 0, '0);
    cyc("R9 clr", 0, 0, 0, 0, 0, 1, 0, '0);
    cyc("R2 validate b0", 1, 0, 0, 0, 0, 0, 0, 7'd10);
    sel("R2 sel");
    cyc("R2 validate b1", 1, 0, 0, 0, 0, 0, 0, 7'd20);
    sel("R2 sel2");
    cyc("R10 validate full", 1, 0, 0, 0, 0, 0, 0, 7'd30);
    sel("R10 sel err");
    sel("R10 sel cleared");
    cyc("R11 clear in IN", 0, 1, 0, 0, 0, 0, 0, '0);
    sel("R11 sel");
    cyc("R5 tok b0", 0, 0, 0, 0, 1, 0, 0, '0);
    cyc("R6 ack b0", 0, 0, 0, 1, 0, 0, 0, '0);
    cyc("R9 set+clr", 0, 0, 0, 0, 1, 1, 0, '0);
    cyc("R9 ack with clr", 0, 0, 0, 1, 0, 1, 0, '0);
    cyc("R9 clr", 0, 0, 0, 0, 0, 1, 0, '0);
    cyc("R6 spurious ack", 0, 0, 0, 1, 0, 0, 0, '0);
    cyc("R6 tok none", 0, 0, 0, 0, 1, 0, 0, '0);
    cyc("R9 clr2", 0, 0, 0, 0, 0, 1, 0, '0);
    set_cfg(1, 0);
    cyc("R8 nak no irq", 0, 0, 0, 0, 1, 0, 0, '0);
    cyc("R8 idle", 0, 0, 0, 0, 0, 0, 0, '0);
    sel("R6 sel after tx");
    // OUT direction
    set_cfg(0, 1);
    cyc("R10 clear empty", 0, 1, 0, 0, 0, 0, 0, '0);
    cyc("R10 err+sel", 0, 1, 0, 0, 0, 0, 1, '0);
    sel("R10 err kept");
    cyc("R7 rx b0", 0, 0, 1, 0, 0, 0, 0, 7'd5);
    cyc("R7 rx b1", 0, 0, 1, 0, 0, 1, 0, 7'd6);
    cyc("R7 rx full", 0, 0, 1, 0, 0, 1, 0, 7'd7);
    cyc("R11 validate in OUT", 1, 0, 0, 0, 0, 1, 0, 7'd99);
    sel("R7 sel");
    cyc("R3 clear b0", 0, 1, 0, 0, 0, 0, 0, '0);
    cyc("R7 rx freed", 0, 0, 1, 0, 0, 0, 0, 7'd8);
    sel("R3 sel b1");
    cyc("R3 clear b1", 0, 1, 0, 0, 0, 0, 0, '0);
    sel("R3 sel b0");
    cyc("R3 clear b0 again", 0, 1, 0, 0, 0, 0, 0, '0);
    sel("R3 sel empty");
    cyc("R9 end", 0, 0, 0, 0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    zero_in();
    check("R4 queue drained", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule